// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic, Logic and Shift Unit

This block is the purely combinational execute stage of a small 16-bit load-store datapath. Two operands arrive on `opa` and `opb` together with a four-bit operation code. The block returns a 16-bit result that covers bitwise logic, wrapping addition and subtraction, signed set-on-less-than and three barrel shifts. The surrounding datapath chooses the operands. For immediate forms it places a sign-extended six-bit constant on `opb`.

A separate flag reports whether `opa - opb` is zero. The flag is produced on every operation code, so the branch logic can compare two registers for equal or not-equal while the result bus carries a different operation.

Top module: `alu16_core`

## Requirements
- R1: Code 0 gives `opa | opb`, code 1 gives `opa & opb`, and code 3 gives `opa ^ opb`.
- R2: Code 2 gives the bitwise inverse of `opa | opb`.
- R3: Code 4 gives `opa + opb` modulo 2^16, and any carry out is dropped.
- R4: Code 5 gives `opa - opb` modulo 2^16, and any borrow is dropped.
- R5: Code 6 gives 1 when `opa` is less than `opb` as signed two's-complement numbers, otherwise 0. Bits 15 to 1 of the result are always 0.
- R6: Code 8 shifts `opa` left by `opb[3:0]` places and fills the vacated bits with 0. Bits `opb[15:4]` have no effect on the result.
- R7: Code 9 shifts `opa` right by `opb[3:0]` places and fills the vacated bits with 0.
- R8: Code 10 shifts `opa` right by `opb[3:0]` places and fills the vacated bits with copies of `opa[15]`.
- R9: `diff_zero` is 1 exactly when `opa` equals `opb`, whatever the operation code.
- R10: Codes 7 and 11 to 15 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opa | input | 16 | First operand; the value shifted by shift codes |
| opb | input | 16 | Second operand; bits 3:0 give the shift amount |
| result | output | 16 | Result of the selected operation |
| diff_zero | output | 1 | High when opa - opb is zero |

## Verification
Random operand pairs are applied under every operation code, including the six unused codes. This shows that each code drives the result bus only through its own path and that the unused codes stay at 0.

Directed vectors cover the cases that separate a correct unit from a slightly wrong one:
- A carry out of bit 15 and a borrow below zero.
- Signed comparisons across the sign boundary, where an unsigned compare would give the opposite answer.
- A shift by 15 of a negative value, which separates zero fill from sign fill.
- A second operand whose upper bits are set but whose low nibble is 0, which shows the upper bits do not reach the shift amount.

Equal operand pairs are applied under non-subtract codes to show that the zero flag does not depend on the selected operation.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_OR  = 4'd0,
        OP_AND = 4'd1,
        OP_NOR = 4'd2,
        OP_XOR = 4'd3,
        OP_ADD = 4'd4,
        OP_SUB = 4'd5,
        OP_SLT = 4'd6,
        OP_SLL = 4'd8,
        OP_SRL = 4'd9,
        OP_SRA = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic [15:0] res;
        logic        zero;
    } alu_out_t;

endpackage

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] or_d,
    output logic [WIDTH-1:0] and_d,
    output logic [WIDTH-1:0] nor_d,
    output logic [WIDTH-1:0] xor_d
);

    always_comb begin
        or_d  = a_in | b_in;
        and_d = a_in & b_in;
        nor_d = ~or_d;
        xor_d = a_in ^ b_in;
    end

    // NOR and OR never share a set bit
    always_comb begin
        AST_NOR_DISJOINT: assert ((nor_d & (a_in | b_in)) == '0); // R2
    end

endmodule

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] add_d,
    output logic [WIDTH-1:0] sub_d,
    output logic [WIDTH-1:0] slt_d,
    output logic             zero_d
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] diff_ext_d;
    logic           sign_diff_d;

    always_comb begin
        add_d       = a_in + b_in;
        diff_ext_d  = {1'b0, a_in} + {1'b0, ~b_in} + {{WIDTH{1'b0}}, 1'b1};
        sub_d       = diff_ext_d[MSB:0];
        sign_diff_d = a_in[MSB] ^ b_in[MSB];
        slt_d       = '0;
        slt_d[0]    = sign_diff_d ? a_in[MSB] : sub_d[MSB];
        zero_d      = (sub_d == '0);
    end

    always_comb begin
        AST_ADD_WRAP: assert ((add_d - b_in) == a_in); // R3
        AST_SUB_WRAP: assert ((sub_d + b_in) == a_in); // R4
        AST_SLT_UPPER: assert (slt_d[MSB:1] == '0); // R5
        AST_SLT_SIGN: assert (!sign_diff_d || (slt_d[0] == a_in[MSB])); // R5
        AST_ZERO_EQ: assert (zero_d == (a_in == b_in)); // R9
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int WIDTH   = 16,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   a_in,
    input  logic [SHAMT_W-1:0] amt_in,
    output logic [WIDTH-1:0]   sll_d,
    output logic [WIDTH-1:0]   srl_d,
    output logic [WIDTH-1:0]   sra_d
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sll_st_d [0:SHAMT_W];
    logic [WIDTH-1:0] srl_st_d [0:SHAMT_W];
    logic [WIDTH-1:0] sra_st_d [0:SHAMT_W];

    assign sll_st_d[0] = a_in;
    assign srl_st_d[0] = a_in;
    assign sra_st_d[0] = a_in;

    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign sll_st_d[i+1] = amt_in[i] ? {sll_st_d[i][MSB-STEP:0], {STEP{1'b0}}} : sll_st_d[i];
        assign srl_st_d[i+1] = amt_in[i] ? {{STEP{1'b0}}, srl_st_d[i][MSB:STEP]} : srl_st_d[i];
        assign sra_st_d[i+1] = amt_in[i] ? {{STEP{sra_st_d[i][MSB]}}, sra_st_d[i][MSB:STEP]} : sra_st_d[i];
    end

    assign sll_d = sll_st_d[SHAMT_W];
    assign srl_d = srl_st_d[SHAMT_W];
    assign sra_d = sra_st_d[SHAMT_W];

    always_comb begin
        AST_SLL_FILL: assert ((amt_in == '0) || (sll_d[0] == 1'b0)); // R6
        AST_SRL_FILL: assert ((amt_in == '0) || (srl_d[MSB] == 1'b0)); // R7
        AST_SRA_SIGN: assert (sra_d[MSB] == a_in[MSB]); // R8
        AST_SRA_SRL_LOW: assert ((sra_d & ~srl_d) == ((sra_d ^ srl_d))); // R8
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int OP_W    = 4,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             diff_zero
);

    logic [WIDTH-1:0] or_d, and_d, nor_d, xor_d;
    logic [WIDTH-1:0] add_d, sub_d, slt_d;
    logic [WIDTH-1:0] sll_d, srl_d, sra_d;
    logic             zero_d;
    logic             known_op_d;
    alu_out_t         out_d;

    alu16_logic #(.WIDTH(WIDTH)) u_logic (
        .a_in (opa),
        .b_in (opb),
        .or_d (or_d),
        .and_d(and_d),
        .nor_d(nor_d),
        .xor_d(xor_d)
    );

    alu16_arith #(.WIDTH(WIDTH)) u_arith (
        .a_in  (opa),
        .b_in  (opb),
        .add_d (add_d),
        .sub_d (sub_d),
        .slt_d (slt_d),
        .zero_d(zero_d)
    );

    alu16_shift #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
        .a_in  (opa),
        .amt_in(opb[SHAMT_W-1:0]),
        .sll_d (sll_d),
        .srl_d (srl_d),
        .sra_d (sra_d)
    );

    always_comb begin
        out_d      = '0;
        known_op_d = 1'b1;
        case (op_sel)
            OP_OR:   out_d.res = or_d;
            OP_AND:  out_d.res = and_d;
            OP_NOR:  out_d.res = nor_d;
            OP_XOR:  out_d.res = xor_d;
            OP_ADD:  out_d.res = add_d;
            OP_SUB:  out_d.res = sub_d;
            OP_SLT:  out_d.res = slt_d;
            OP_SLL:  out_d.res = sll_d;
            OP_SRL:  out_d.res = srl_d;
            OP_SRA:  out_d.res = sra_d;
            default: known_op_d = 1'b0;
        endcase
        out_d.zero = zero_d;
    end

    assign result    = out_d.res;
    assign diff_zero = out_d.zero;

    always_comb begin
        AST_UNUSED_ZERO: assert (known_op_d || (result == '0)); // R10
        AST_SLT_BOOL: assert ((op_sel != OP_SLT) || (result <= 16'd1)); // R5
    end

endmodule

// File: tb/alu16_core_test.sv
module alu16_core_test;

    logic        clk = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [15:0] result;
    logic        diff_zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    alu16_core uut (
        .op_sel   (op_sel),
        .opa      (opa),
        .opb      (opb),
        .result   (result),
        .diff_zero(diff_zero)
    );

    function automatic logic [15:0] exp_res(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r;
        int sh;
        sh = int'(b & 16'h000F);
        r  = '0;
        case (op)
            4'd0: r = a | b;
            4'd1: r = a & b;
            4'd2: r = ~(a | b);
            4'd3: r = a ^ b;
            4'd4: r = a + b;
            4'd5: r = a - b;
            4'd6: r = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
            4'd8: begin
                r = a;
                for (int k = 0; k < sh; k++) r = {r[14:0], 1'b0};
            end
            4'd9: begin
                r = a;
                for (int k = 0; k < sh; k++) r = {1'b0, r[15:1]};
            end
            4'd10: begin
                r = a;
                for (int k = 0; k < sh; k++) r = {r[15], r[15:1]};
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd3: return "R1";
            4'd2:  return "R2";
            4'd4:  return "R3";
            4'd5:  return "R4";
            4'd6:  return "R5";
            4'd8:  return "R6";
            4'd9:  return "R7";
            4'd10: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_sel = op;
        opa    = a;
        opb    = b;
        #1;
        n_checks++;
        if (result !== exp_res(op, a, b)) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
                     op_tag(op), op, a, b, result, exp_res(op, a, b));
        end
        n_checks++;
        if (diff_zero !== (a == b)) begin
            n_fail++;
            $display("FAIL R9 op=%0d a=%h b=%h diff_zero actual=%b expected=%b",
                     op, a, b, diff_zero, (a == b));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_0A1F);
        // reset state: all-zero inputs give OR of zeros and an asserted zero flag
        apply(4'd0, 16'h0000, 16'h0000); // R1 R9
        // R1 directed
        apply(4'd0, 16'hF0F0, 16'h0FF0);
        apply(4'd1, 16'hF0F0, 16'h0FF0);
        apply(4'd3, 16'hF0F0, 16'h0FF0);
        // R2 directed
        apply(4'd2, 16'h1234, 16'h8001);
        // R3 carry out dropped
        apply(4'd4, 16'hFFFF, 16'h0001);
        apply(4'd4, 16'h7FFF, 16'h0001);
        // R4 borrow dropped
        apply(4'd5, 16'h0000, 16'h0001);
        apply(4'd5, 16'h8000, 16'h0001);
        // R5 signed compare across the sign boundary
        apply(4'd6, 16'h8000, 16'h0001);
        apply(4'd6, 16'h0001, 16'h8000);
        apply(4'd6, 16'h7FFF, 16'h8000);
        apply(4'd6, 16'hFFFF, 16'hFFFF);
        apply(4'd6, 16'hFFFE, 16'hFFFF);
        // R6 upper bits of opb ignored, amount 0 and 15
        apply(4'd8, 16'hA5A5, 16'hFFF0);
        apply(4'd8, 16'h0003, 16'h000F);
        apply(4'd8, 16'h0003, 16'hFFE1);
        // R7 zero fill
        apply(4'd9, 16'h8000, 16'h000F);
        apply(4'd9, 16'hFFFF, 16'h0004);
        // R8 sign fill
        apply(4'd10, 16'h8000, 16'h000F);
        apply(4'd10, 16'h4000, 16'h000E);
        apply(4'd10, 16'hF00F, 16'hFFF4);
        // R9 zero flag under other codes with equal operands
        apply(4'd4, 16'h1357, 16'h1357);
        apply(4'd8, 16'hBEEF, 16'hBEEF);
        apply(4'd13, 16'h0042, 16'h0042);
        // R10 unused codes
        for (int c = 11; c < 16; c++) apply(4'(c), 16'hFFFF, 16'h1234);
        apply(4'd7, 16'hFFFF, 16'h0000);
        // random mix over all codes
        for (int i = 0; i < 1600; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = (i % 8 == 0) ? ra : 16'($urandom);
            if (i % 5 == 1) rb = {{10{rb[5]}}, rb[5:0]};
            apply(4'(i % 16), ra, rb);
        end
        finish_run();
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule